// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block keeps a record of the cache requests a pipeline has in flight. It has a fixed pool of slots, and each slot holds one request: the issuing thread, its sequence number, its address and two flags. The first flag says the memory access is still outstanding. The second says the request has been cancelled but its response has not yet come back. A stage asks for a slot with a thread, a sequence number, an address and a port type. In the same cycle it gets back either a slot index or a refusal.

On a data port, a new request is refused while any live slot holds the same address. This keeps accesses to one location in order. On an instruction-fetch port, only free space matters. Slots are released in three ways: by an explicit free, by a squash that cancels younger work of one thread, or by the memory response of a request that was cancelled while its access was in flight. A squash never drops a slot whose access is outstanding. That slot stays allocated, and its address keeps blocking data requests, until the response returns.

Top module: `mtrk_top`

## Requirements
- R1: With `alloc_fetch` low (data port), a request whose address equals the address of any live slot is refused: `alloc_deny` is 1 and `alloc_grant` is 0 in the same cycle.
- R2: With `alloc_fetch` high (instruction-fetch port), the address comparison is skipped. A request for an address already held by a live slot is granted if a slot is free.
- R3: When all slots are live, every request is refused.
- R4: A request with `alloc_addr_vld` low raises `alloc_err` and `alloc_deny` in the same cycle and allocates nothing.
- R5: A granted request takes the lowest-index free slot. That index is on `alloc_slot` in the request cycle, and the slot's bit in `live_mask` is 1 from the next cycle. The address blocks data requests until the slot is released, and after release the same address is granted again.
- R6: A squash touches only live slots whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq`. The comparison is unsigned over 16 bits.
- R7: A squashed slot with no outstanding access is released: its `live_mask` bit is 0 from the next cycle.
- R8: A squashed slot with an outstanding access stays live. Its `sqsh_mask` bit becomes 1, and it keeps refusing data requests to its address.
- R9: A response on `rsp_slot` clears that slot's `pend_mask` bit. If the slot was squashed, the slot is also released in that cycle.
- R10: While reset is asserted, and right after it, `live_mask`, `pend_mask` and `sqsh_mask` are all 0. An asynchronous reset in the middle of a run empties every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alloc_req | input | 1 | Request a slot this cycle |
| alloc_addr_vld | input | 1 | The request carries a valid address |
| alloc_fetch | input | 1 | 1: instruction-fetch port (no address check); 0: data port |
| alloc_tid | input | TID_W | Thread of the request |
| alloc_seq | input | SEQ_W | Sequence number of the request |
| alloc_addr | input | ADDR_W | Address of the request |
| alloc_grant | output | 1 | The request got a slot |
| alloc_deny | output | 1 | The request was refused |
| alloc_err | output | 1 | The request had no valid address |
| alloc_slot | output | IDX_W | Index of the granted slot |
| issue_vld | input | 1 | The memory access of a slot was sent |
| issue_slot | input | IDX_W | Slot whose access was sent |
| rsp_vld | input | 1 | A memory response returned |
| rsp_slot | input | IDX_W | Slot the response belongs to |
| free_vld | input | 1 | Release a slot explicitly |
| free_slot | input | IDX_W | Slot to release |
| sq_vld | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Squash boundary; strictly younger entries are affected |
| live_mask | output | NUM_SLOTS | One bit per allocated slot |
| pend_mask | output | NUM_SLOTS | One bit per slot with an outstanding access |
| sqsh_mask | output | NUM_SLOTS | One bit per squashed slot awaiting its response |

## Verification
A wrong slot flag shows at the ports within one cycle: `live_mask`, `pend_mask` and `sqsh_mask` are read out after every step, and the very next request shows a grant where a refusal was due, or the other way round. A bad stored address or sequence number stays hidden until a later data request to that address or a later squash of that thread. For that reason the stimulus repeats addresses across the data and fetch port types, and squashes at, just under and far above stored sequence numbers, including one number that has its top bit set. Releases deferred behind outstanding accesses are checked at the cycle of the response, so a slot freed one cycle too early or too late shows in the mask.

// File: rtl/mtrk_pkg.sv
package mtrk_pkg;

  // outcome of one allocation attempt
  typedef enum logic [1:0] {
    ALLOC_IDLE  = 2'd0,
    ALLOC_GRANT = 2'd1,
    ALLOC_BUSY  = 2'd2,
    ALLOC_BADA  = 2'd3
  } alloc_res_e;

  // per-slot flag bundle
  typedef struct packed {
    logic live;
    logic pend;
    logic sqsh;
  } slot_flags_t;

endpackage

// File: rtl/mtrk_rst_sync.sv
module mtrk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/mtrk_slot.sv
module mtrk_slot #(
  parameter int TID_W  = 2,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [TID_W-1:0]  ld_tid,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              issue_hit,
  input  logic              rsp_hit,
  input  logic              free_hit,
  input  logic              sq_vld,
  input  logic [TID_W-1:0]  sq_tid,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic              live_o,
  output logic              pend_o,
  output logic              sqsh_o,
  output logic [ADDR_W-1:0] addr_o
);

  import mtrk_pkg::*;

  slot_flags_t       flg_q, flg_d;
  logic [TID_W-1:0]  tid_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sq_hit;
  logic              pend_left;

  // squash applies to same thread, strictly younger (unsigned)
  assign sq_hit    = sq_vld && flg_q.live && (tid_q == sq_tid) && (seq_q > sq_seq);
  assign pend_left = flg_q.pend && !rsp_hit;

  always_comb begin
    flg_d = flg_q;
    if (ld) begin
      flg_d.live = 1'b1;
      flg_d.pend = 1'b0;
      flg_d.sqsh = 1'b0;
    end else if (flg_q.live) begin
      if ((rsp_hit && flg_q.sqsh) || free_hit) begin
        flg_d = '0;
      end else if (sq_hit) begin
        if (pend_left) begin
          flg_d.sqsh = 1'b1;
          flg_d.pend = 1'b1;
        end else begin
          flg_d = '0;
        end
      end else begin
        flg_d.pend = pend_left || (issue_hit && !flg_q.sqsh);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  // payload written only on load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q  <= '0;
      seq_q  <= '0;
      addr_q <= '0;
    end else if (ld) begin
      tid_q  <= ld_tid;
      seq_q  <= ld_seq;
      addr_q <= ld_addr;
    end
  end

  assign live_o = flg_q.live;
  assign pend_o = flg_q.pend;
  assign sqsh_o = flg_q.sqsh;
  assign addr_o = addr_q;

endmodule

// File: rtl/mtrk_match.sv
module mtrk_match #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input  logic [NUM_SLOTS-1:0]        live,
  input  logic [NUM_SLOTS*ADDR_W-1:0] addr_flat,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        any_hit
);

  logic [NUM_SLOTS-1:0] hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign hit[g] = live[g] && (addr_flat[g*ADDR_W +: ADDR_W] == req_addr);
  end

  assign any_hit = |hit;

endmodule

// File: rtl/mtrk_pick.sv
module mtrk_pick #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_SLOTS-1:0] live,
  output logic                 any_free,
  output logic [IDX_W-1:0]     idx
);

  // lowest-index free slot
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!live[i]) begin
        any_free = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mtrk_top.sv
module mtrk_top #(
  parameter int NUM_SLOTS = 4,
  parameter int TID_W     = 2,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_req,
  input  logic                 alloc_addr_vld,
  input  logic                 alloc_fetch,
  input  logic [TID_W-1:0]     alloc_tid,
  input  logic [SEQ_W-1:0]     alloc_seq,
  input  logic [ADDR_W-1:0]    alloc_addr,
  output logic                 alloc_grant,
  output logic                 alloc_deny,
  output logic                 alloc_err,
  output logic [IDX_W-1:0]     alloc_slot,
  input  logic                 issue_vld,
  input  logic [IDX_W-1:0]     issue_slot,
  input  logic                 rsp_vld,
  input  logic [IDX_W-1:0]     rsp_slot,
  input  logic                 free_vld,
  input  logic [IDX_W-1:0]     free_slot,
  input  logic                 sq_vld,
  input  logic [TID_W-1:0]     sq_tid,
  input  logic [SEQ_W-1:0]     sq_seq,
  output logic [NUM_SLOTS-1:0] live_mask,
  output logic [NUM_SLOTS-1:0] pend_mask,
  output logic [NUM_SLOTS-1:0] sqsh_mask
);

  import mtrk_pkg::*;

  logic                        rst_sn;
  logic [NUM_SLOTS*ADDR_W-1:0] addr_flat;
  logic                        addr_hit;
  logic                        any_free;
  logic [IDX_W-1:0]            pick_idx;
  alloc_res_e                  res;

  mtrk_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mtrk_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_match (
    .live      (live_mask),
    .addr_flat (addr_flat),
    .req_addr  (alloc_addr),
    .any_hit   (addr_hit)
  );

  mtrk_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .live     (live_mask),
    .any_free (any_free),
    .idx      (pick_idx)
  );

  // allocation decision, resolved in the request cycle
  always_comb begin
    res = ALLOC_IDLE;
    if (alloc_req) begin
      if (!alloc_addr_vld)                  res = ALLOC_BADA;
      else if (!any_free)                   res = ALLOC_BUSY;
      else if (!alloc_fetch && addr_hit)    res = ALLOC_BUSY;
      else                                  res = ALLOC_GRANT;
    end
  end

  assign alloc_grant = (res == ALLOC_GRANT);
  assign alloc_deny  = (res == ALLOC_BUSY) || (res == ALLOC_BADA);
  assign alloc_err   = (res == ALLOC_BADA);
  assign alloc_slot  = pick_idx;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic ld_g, iss_g, rsp_g, free_g;
    assign ld_g   = alloc_grant && (pick_idx   == IDX_W'(g));
    assign iss_g  = issue_vld   && (issue_slot == IDX_W'(g));
    assign rsp_g  = rsp_vld     && (rsp_slot   == IDX_W'(g));
    assign free_g = free_vld    && (free_slot  == IDX_W'(g));

    mtrk_slot #(.TID_W(TID_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_sn),
      .ld        (ld_g),
      .ld_tid    (alloc_tid),
      .ld_seq    (alloc_seq),
      .ld_addr   (alloc_addr),
      .issue_hit (iss_g),
      .rsp_hit   (rsp_g),
      .free_hit  (free_g),
      .sq_vld    (sq_vld),
      .sq_tid    (sq_tid),
      .sq_seq    (sq_seq),
      .live_o    (live_mask[g]),
      .pend_o    (pend_mask[g]),
      .sqsh_o    (sqsh_mask[g]),
      .addr_o    (addr_flat[g*ADDR_W +: ADDR_W])
    );
  end

endmodule

// File: rtl/mtrk_chk.sv
module mtrk_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_req,
  input logic                 alloc_addr_vld,
  input logic                 alloc_grant,
  input logic                 alloc_deny,
  input logic                 alloc_err,
  input logic [IDX_W-1:0]     alloc_slot,
  input logic                 rsp_vld,
  input logic [IDX_W-1:0]     rsp_slot,
  input logic [NUM_SLOTS-1:0] live_mask,
  input logic [NUM_SLOTS-1:0] pend_mask,
  input logic [NUM_SLOTS-1:0] sqsh_mask
);

  a_r3_full_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && (&live_mask)) |-> (alloc_deny && !alloc_grant));

  a_r4_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_addr_vld) |-> (alloc_err && !alloc_grant));

  a_r5_grant_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> !live_mask[alloc_slot]);

  a_r5_grant_goes_live: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> live_mask[$past(alloc_slot)]);

  a_r8_sqsh_holds_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ((sqsh_mask & ~pend_mask) == '0) && ((pend_mask & ~live_mask) == '0));

  a_r9_rsp_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && sqsh_mask[rsp_slot]) |=> !live_mask[$past(rsp_slot)]);

endmodule

bind mtrk_top mtrk_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sn),
  .alloc_req      (alloc_req),
  .alloc_addr_vld (alloc_addr_vld),
  .alloc_grant    (alloc_grant),
  .alloc_deny     (alloc_deny),
  .alloc_err      (alloc_err),
  .alloc_slot     (alloc_slot),
  .rsp_vld        (rsp_vld),
  .rsp_slot       (rsp_slot),
  .live_mask      (live_mask),
  .pend_mask      (pend_mask),
  .sqsh_mask      (sqsh_mask)
);

// File: tb/tb_mtrk_top.sv
`timescale 1ns/1ps
module tb_mtrk_top;

  localparam logic [2:0] OP_ALLOC = 3'd0;
  localparam logic [2:0] OP_FREE  = 3'd1;
  localparam logic [2:0] OP_ISSUE = 3'd2;
  localparam logic [2:0] OP_RSP   = 3'd3;
  localparam logic [2:0] OP_SQ    = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  tid;
    logic [15:0] seq;
    logic [31:0] addr;
    logic        fetch;
    logic        avld;
    logic [1:0]  idx;
    logic [3:0]  rq;
    logic        eg;
    logic [1:0]  es;
    logic        ed;
    logic        ee;
    logic [3:0]  el;
    logic [3:0]  ep;
    logic [3:0]  eq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_ALLOC, 2'd0, 16'd10,    32'h100, 1'b0, 1'b1, 2'd0, 4'd5,  1'b1, 2'd0, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R5
    '{OP_ALLOC, 2'd0, 16'd11,    32'h100, 1'b0, 1'b1, 2'd0, 4'd1,  1'b0, 2'd0, 1'b1, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R1
    '{OP_ALLOC, 2'd0, 16'd11,    32'h100, 1'b1, 1'b1, 2'd0, 4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'b0011, 4'b0000, 4'b0000}, // R2
    '{OP_ALLOC, 2'd0, 16'd12,    32'h700, 1'b0, 1'b0, 2'd0, 4'd4,  1'b0, 2'd0, 1'b1, 1'b1, 4'b0011, 4'b0000, 4'b0000}, // R4
    '{OP_ALLOC, 2'd1, 16'd20,    32'h200, 1'b0, 1'b1, 2'd0, 4'd5,  1'b1, 2'd2, 1'b0, 1'b0, 4'b0111, 4'b0000, 4'b0000}, // R5
    '{OP_ALLOC, 2'd1, 16'd21,    32'h300, 1'b0, 1'b1, 2'd0, 4'd5,  1'b1, 2'd3, 1'b0, 1'b0, 4'b1111, 4'b0000, 4'b0000}, // R5
    '{OP_ALLOC, 2'd0, 16'd30,    32'h400, 1'b1, 1'b1, 2'd0, 4'd3,  1'b0, 2'd0, 1'b1, 1'b0, 4'b1111, 4'b0000, 4'b0000}, // R3
    '{OP_FREE,  2'd0, 16'd0,     32'h0,   1'b0, 1'b0, 2'd1, 4'd5,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1101, 4'b0000, 4'b0000}, // R5
    '{OP_ALLOC, 2'd0, 16'd31,    32'h500, 1'b0, 1'b1, 2'd0, 4'd5,  1'b1, 2'd1, 1'b0, 1'b0, 4'b1111, 4'b0000, 4'b0000}, // R5
    '{OP_ISSUE, 2'd0, 16'd0,     32'h0,   1'b0, 1'b0, 2'd2, 4'd9,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1111, 4'b0100, 4'b0000}, // R9
    '{OP_ISSUE, 2'd0, 16'd0,     32'h0,   1'b0, 1'b0, 2'd3, 4'd9,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1111, 4'b1100, 4'b0000}, // R9
    '{OP_SQ,    2'd1, 16'd20,    32'h0,   1'b0, 1'b0, 2'd0, 4'd8,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1111, 4'b1100, 4'b1000}, // R8 R6
    '{OP_FREE,  2'd0, 16'd0,     32'h0,   1'b0, 1'b0, 2'd0, 4'd5,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1110, 4'b1100, 4'b1000}, // R5
    '{OP_ALLOC, 2'd2, 16'd1,     32'h300, 1'b0, 1'b1, 2'd0, 4'd8,  1'b0, 2'd0, 1'b1, 1'b0, 4'b1110, 4'b1100, 4'b1000}, // R8
    '{OP_SQ,    2'd0, 16'd10,    32'h0,   1'b0, 1'b0, 2'd0, 4'd7,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1100, 4'b1100, 4'b1000}, // R7
    '{OP_RSP,   2'd0, 16'd0,     32'h0,   1'b0, 1'b0, 2'd2, 4'd9,  1'b0, 2'd0, 1'b0, 1'b0, 4'b1100, 4'b1000, 4'b1000}, // R9
    '{OP_RSP,   2'd0, 16'd0,     32'h0,   1'b0, 1'b0, 2'd3, 4'd9,  1'b0, 2'd0, 1'b0, 1'b0, 4'b0100, 4'b0000, 4'b0000}, // R9
    '{OP_ALLOC, 2'd2, 16'h8000,  32'h300, 1'b0, 1'b1, 2'd0, 4'd5,  1'b1, 2'd0, 1'b0, 1'b0, 4'b0101, 4'b0000, 4'b0000}, // R5
    '{OP_SQ,    2'd1, 16'hFFFF,  32'h0,   1'b0, 1'b0, 2'd0, 4'd6,  1'b0, 2'd0, 1'b0, 1'b0, 4'b0101, 4'b0000, 4'b0000}, // R6
    '{OP_SQ,    2'd2, 16'd1,     32'h0,   1'b0, 1'b0, 2'd0, 4'd6,  1'b0, 2'd0, 1'b0, 1'b0, 4'b0100, 4'b0000, 4'b0000}, // R6
    '{OP_SQ,    2'd3, 16'd0,     32'h0,   1'b0, 1'b0, 2'd0, 4'd6,  1'b0, 2'd0, 1'b0, 1'b0, 4'b0100, 4'b0000, 4'b0000}, // R6
    '{OP_SQ,    2'd1, 16'd19,    32'h0,   1'b0, 1'b0, 2'd0, 4'd7,  1'b0, 2'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0000}  // R7
  };

  logic        clk, rst_n;
  logic        alloc_req, alloc_addr_vld, alloc_fetch;
  logic [1:0]  alloc_tid;
  logic [15:0] alloc_seq;
  logic [31:0] alloc_addr;
  logic        alloc_grant, alloc_deny, alloc_err;
  logic [1:0]  alloc_slot;
  logic        issue_vld, rsp_vld, free_vld, sq_vld;
  logic [1:0]  issue_slot, rsp_slot, free_slot, sq_tid;
  logic [15:0] sq_seq;
  logic [3:0]  live_mask, pend_mask, sqsh_mask;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  mtrk_top dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_addr_vld(alloc_addr_vld), .alloc_fetch(alloc_fetch),
    .alloc_tid(alloc_tid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
    .alloc_grant(alloc_grant), .alloc_deny(alloc_deny), .alloc_err(alloc_err),
    .alloc_slot(alloc_slot),
    .issue_vld(issue_vld), .issue_slot(issue_slot),
    .rsp_vld(rsp_vld), .rsp_slot(rsp_slot),
    .free_vld(free_vld), .free_slot(free_slot),
    .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .live_mask(live_mask), .pend_mask(pend_mask), .sqsh_mask(sqsh_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_req = 1'b0; alloc_addr_vld = 1'b0; alloc_fetch = 1'b0;
    alloc_tid = '0; alloc_seq = '0; alloc_addr = '0;
    issue_vld = 1'b0; issue_slot = '0; rsp_vld = 1'b0; rsp_slot = '0;
    free_vld = 1'b0; free_slot = '0; sq_vld = 1'b0; sq_tid = '0; sq_seq = '0;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    string tag;
    tag = $sformatf("R%0d step%0d", v.rq, n);
    @(negedge clk);
    case (v.op)
      OP_ALLOC: begin
        alloc_req = 1'b1; alloc_addr_vld = v.avld; alloc_fetch = v.fetch;
        alloc_tid = v.tid; alloc_seq = v.seq; alloc_addr = v.addr;
      end
      OP_FREE:  begin free_vld  = 1'b1; free_slot  = v.idx; end
      OP_ISSUE: begin issue_vld = 1'b1; issue_slot = v.idx; end
      OP_RSP:   begin rsp_vld   = 1'b1; rsp_slot   = v.idx; end
      default:  begin sq_vld = 1'b1; sq_tid = v.tid; sq_seq = v.seq; end
    endcase
    #1;
    if (v.op == OP_ALLOC) begin
      chk(tag, "grant", 32'(alloc_grant), 32'(v.eg));
      chk(tag, "deny",  32'(alloc_deny),  32'(v.ed));
      chk(tag, "err",   32'(alloc_err),   32'(v.ee));
      if (v.eg) chk(tag, "slot", 32'(alloc_slot), 32'(v.es));
    end
    @(posedge clk);
    #1;
    idle_inputs();
    chk(tag, "live", 32'(live_mask), 32'(v.el));
    chk(tag, "pend", 32'(pend_mask), 32'(v.ep));
    chk(tag, "sqsh", 32'(sqsh_mask), 32'(v.eq));
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "live in reset", 32'(live_mask), 32'h0);
    chk("R10", "pend in reset", 32'(pend_mask), 32'h0);
    chk("R10", "sqsh in reset", 32'(sqsh_mask), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "live after release", 32'(live_mask), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R10: asynchronous reset mid-run empties every slot
    run_vec('{OP_ALLOC, 2'd0, 16'd5, 32'h900, 1'b0, 1'b1, 2'd0, 4'd5, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000}, 100);
    run_vec('{OP_ISSUE, 2'd0, 16'd0, 32'h0, 1'b0, 1'b0, 2'd0, 4'd9, 1'b0, 2'd0, 1'b0, 1'b0, 4'b0001, 4'b0001, 4'b0000}, 101);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", "live mid-run reset", 32'(live_mask), 32'h0);
    chk("R10", "pend mid-run reset", 32'(pend_mask), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 boundary after reset: the old address is no longer in the conflict set
    run_vec('{OP_ALLOC, 2'd0, 16'd6, 32'h900, 1'b0, 1'b1, 2'd0, 4'd10, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000}, 102);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule